// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is the data path of an eight-pin general-purpose I/O port. It holds a direction register, which sets each pin to drive or to sense, and a data register. Output pins take their level from the data register. Input pins sample their pad through a two-stage synchronizer and copy the result into the data register on every clock. Pins set as inputs drive a fixed idle level, high by default, on their output lines.

A bus access to the low data window uses part of its own address as a pin mask. Byte-offset bits [9:2] choose which pins a read shows and which pins a write may change. Software can therefore set or clear any group of pins in a single write, with no read-modify-write sequence. Reads return zero on pins outside the mask. Writes never alter pins that are set as inputs.

For every input pin, the block gives the interrupt logic a one-cycle change pulse. The pulse is raised when the synchronized pad level differs from the level last captured for that pin.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, the direction register and the data register read 0, `pad_out` is 0xFF, and `in_chg` is 0.
- R2: A read at a byte offset whose bits [11:10] are 0 returns the data register ANDed with offset bits [9:2]. Bit k of that field selects pin k.
- R3: A write in the data window updates exactly those data bits that are set both in offset bits [9:2] and in the direction register. All other data bits keep their value, apart from input capture (R6).
- R4: The direction register sits at byte offset 0x400 and can be read and written. A 1 in bit k makes pin k an output.
- R5: `pad_out[k]` equals data bit k when pin k is an output, and 1 when pin k is an input.
- R6: The level on an input pin passes through two flops and is written into its data bit on the next edge. A change on `pad_in` becomes readable over the bus three rising edges later.
- R7: A change on `pad_in` at an output pin leaves that pin's data bit, its `pad_out` bit and its `in_chg` bit unchanged.
- R8: `in_chg[k]` is 1 for one cycle when pin k is an input and its synchronized level differs from its captured data bit. It is always 0 for output pins.
- R9: A read at an offset that is neither in the data window nor 0x400 returns 0. A write there changes neither register.
- R10: When a bus write and an input capture fall on the same edge, both take effect. Capture on that edge uses the direction value held before the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle as the access |
| pad_in | input | 8 | Pad input levels, asynchronous |
| pad_out | output | 8 | Levels driven toward the pads |
| in_chg | output | 8 | Per-pin input change pulse for the interrupt logic |

## Verification
Two functions can land on the same clock edge: the capture of a synchronized input level and a bus write. The bench waits until `in_chg` shows a pending capture and then places a data-window write on exactly that edge. It checks that the written output bits and the captured input bit both appear in the next read. It then places a direction write that turns a pin with a pending capture into an output. The value driven on `pad_out` shows whether the capture used the old direction value or the new one.

// File: rtl/gmp_pkg.sv
package gmp_pkg;
    parameter int PINS      = 8;
    parameter int ADDR_W    = 12;
    parameter int MASK_LSB  = 2;
    parameter int SYNC_LEN  = 2;
    parameter logic [ADDR_W-1:0] DIR_OFS = 12'h400;

    localparam int MASK_MSB = MASK_LSB + PINS - 1;
    localparam int WIN_LSB  = MASK_LSB + PINS;

    typedef logic [PINS-1:0] pins_t;

    typedef enum logic [1:0] {
        RGN_DATA = 2'd0,
        RGN_DIR  = 2'd1,
        RGN_NONE = 2'd2
    } region_e;

    typedef struct packed {
        region_e rgn;
        pins_t   mask;
    } access_t;

    function automatic access_t decode_addr(input logic [ADDR_W-1:0] a);
        access_t r;
        r.mask = '0;
        if (a[ADDR_W-1:WIN_LSB] == '0) begin
            r.rgn  = RGN_DATA;
            r.mask = a[MASK_MSB:MASK_LSB];
        end else if (a == DIR_OFS) begin
            r.rgn = RGN_DIR;
        end else begin
            r.rgn = RGN_NONE;
        end
        return r;
    endfunction
endpackage

// File: rtl/gmp_sync.sv
module gmp_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= '0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gmp_decode.sv
module gmp_decode
    import gmp_pkg::*;
(
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output access_t           acc,
    output logic              wr_data,
    output logic              wr_dir,
    output logic              rd_none
);
    always_comb begin
        acc     = decode_addr(addr);
        wr_data = sel && wr && (acc.rgn == RGN_DATA);
        wr_dir  = sel && wr && (acc.rgn == RGN_DIR);
        rd_none = sel && !wr && (acc.rgn == RGN_NONE);
    end
endmodule

// File: rtl/gmp_core.sv
module gmp_core
    import gmp_pkg::*;
#(
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_data,
    input  logic  wr_dir,
    input  pins_t mask,
    input  pins_t wdata,
    input  pins_t in_sync,
    output pins_t dir_q,
    output pins_t data_q,
    output pins_t chg,
    output pins_t drive
);
    pins_t wmask;
    pins_t data_nxt;

    always_comb begin
        wmask    = wr_data ? (mask & dir_q) : '0;
        data_nxt = (data_q & dir_q & ~wmask) | (wdata & wmask) | (in_sync & ~dir_q);
        chg      = ~dir_q & (in_sync ^ data_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            data_q <= '0;
        end else begin
            data_q <= data_nxt;
            if (wr_dir) dir_q <= wdata;
        end
    end

    genvar k;
    generate
        for (k = 0; k < PINS; k++) begin : g_pin
            assign drive[k] = dir_q[k] ? data_q[k] : IDLE_LVL;
        end
    endgenerate
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
    import gmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   in_chg
);
    access_t acc;
    logic    wr_data_win;
    logic    wr_dir_hit;
    logic    rd_unmapped;
    pins_t   acc_mask;
    pins_t   in_sync;
    pins_t   dir_q;
    pins_t   data_q;

    gmp_decode u_dec (
        .sel     (bus_sel),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .acc     (acc),
        .wr_data (wr_data_win),
        .wr_dir  (wr_dir_hit),
        .rd_none (rd_unmapped)
    );

    assign acc_mask = acc.mask;

    gmp_sync #(.W(PINS), .STAGES(SYNC_LEN)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (in_sync)
    );

    gmp_core u_core (
        .clk     (clk),
        .rst     (rst),
        .wr_data (wr_data_win),
        .wr_dir  (wr_dir_hit),
        .mask    (acc_mask),
        .wdata   (bus_wdata),
        .in_sync (in_sync),
        .dir_q   (dir_q),
        .data_q  (data_q),
        .chg     (in_chg),
        .drive   (pad_out)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (acc.rgn)
                RGN_DATA: bus_rdata = data_q & acc.mask;
                RGN_DIR:  bus_rdata = dir_q;
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gmp_chk.sv
module gmp_chk
    import gmp_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  wr_data,
    input logic  wr_dir,
    input logic  rd_none,
    input pins_t mask,
    input pins_t wdata,
    input pins_t dir,
    input pins_t data,
    input pins_t sync,
    input pins_t in_chg,
    input pins_t pad_out,
    input pins_t rdata
);
    p_dir_write_r4: assert property (@(posedge clk) disable iff (rst)
        wr_dir |=> dir == $past(wdata));

    p_masked_write_r3: assert property (@(posedge clk) disable iff (rst)
        wr_data |=> ((data & $past(dir) & ~$past(mask)) ==
                     ($past(data) & $past(dir) & ~$past(mask))));

    p_out_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !wr_data |=> ((data & $past(dir)) == ($past(data) & $past(dir))));

    p_idle_high_r5: assert property (@(posedge clk) disable iff (rst)
        (pad_out | dir) == '1);

    p_chg_capture_r8: assert property (@(posedge clk) disable iff (rst)
        (in_chg != '0) |=> ((data & $past(in_chg)) == ($past(sync) & $past(in_chg))));

    p_chg_inputs_only_r8: assert property (@(posedge clk) disable iff (rst)
        (in_chg & dir) == '0);

    p_unmapped_read_r9: assert property (@(posedge clk) disable iff (rst)
        rd_none |-> rdata == '0);
endmodule

bind gpio_mask_port gmp_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_data (wr_data_win),
    .wr_dir  (wr_dir_hit),
    .rd_none (rd_unmapped),
    .mask    (acc_mask),
    .wdata   (bus_wdata),
    .dir     (dir_q),
    .data    (data_q),
    .sync    (in_sync),
    .in_chg  (in_chg),
    .pad_out (pad_out),
    .rdata   (bus_rdata)
);

// File: tb/sim_gpio_mask_port.sv
module sim_gpio_mask_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out;
    logic [7:0]  in_chg;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_mask_port u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .in_chg(in_chg)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after the write edge
    task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        bus_read(12'h400, v); chk("R1 dir after reset", v, 8'h00);
        bus_read(12'h3FC, v); chk("R1 data after reset", v, 8'h00);
        chk("R1 pad_out after reset", pad_out, 8'hFF);
        chk("R1 in_chg after reset", in_chg, 8'h00);
    endtask

    task automatic t_dir();
        logic [7:0] v;
        bus_write(12'h400, 8'hF0);
        bus_read(12'h400, v); chk("R4 dir readback", v, 8'hF0);
        chk("R5 pad_out idle inputs high", pad_out, 8'h0F);
    endtask

    task automatic t_masked_write();
        logic [7:0] v;
        bus_write(12'h3FC, 8'hFF);
        bus_read(12'h3FC, v); chk("R3 full-mask write", v, 8'hF0);
        chk("R5 pad_out outputs high", pad_out, 8'hFF);
        bus_write(12'h0C0, 8'h00);             // mask 0x30
        bus_read(12'h3FC, v); chk("R3 partial-mask clear", v, 8'hC0);
        chk("R5 pad_out after clear", pad_out, 8'hCF);
        bus_write(12'h03C, 8'hFF);             // mask 0x0F, all inputs
        bus_read(12'h3FC, v); chk("R3 input pins not written", v, 8'hC0);
    endtask

    task automatic t_masked_read();
        logic [7:0] v;
        bus_read(12'h100, v); chk("R2 read mask 0x40", v, 8'h40);
        bus_read(12'h080, v); chk("R2 read mask 0x20", v, 8'h00);
        bus_read(12'h300, v); chk("R2 read mask 0xC0", v, 8'hC0);
    endtask

    task automatic t_input();
        logic [7:0] v;
        pad_in = 8'h35;                        // bits 4,5 are outputs
        @(negedge clk);
        chk("R6 no change after one edge", in_chg, 8'h00);
        @(negedge clk);
        chk("R8 change pulse inputs only", in_chg, 8'h05);
        chk("R7 pad_out unaffected", pad_out, 8'hCF);
        @(negedge clk);
        chk("R8 pulse ends after capture", in_chg, 8'h00);
        bus_read(12'h3FC, v); chk("R6 R7 captured data", v, 8'hC5);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        bus_write(12'h404, 8'hFF);
        bus_read(12'h404, v); chk("R9 unmapped read zero", v, 8'h00);
        bus_read(12'h400, v); chk("R9 dir untouched", v, 8'hF0);
        bus_write(12'h800, 8'h00);
        bus_read(12'h3FC, v); chk("R9 data untouched", v, 8'hC5);
        bus_read(12'h800, v); chk("R9 high offset read zero", v, 8'h00);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        pad_in = 8'h37;                        // pin 1 rises
        @(negedge clk);
        @(negedge clk);
        chk("R8 pending capture pin1", in_chg, 8'h02);
        bus_write(12'h3FC, 8'h00);             // same edge as capture
        bus_read(12'h3FC, v); chk("R10 write and capture together", v, 8'h07);
        chk("R10 pad_out after collide", pad_out, 8'h0F);
        pad_in = 8'h36;                        // pin 0 falls
        @(negedge clk);
        @(negedge clk);
        chk("R8 pending capture pin0", in_chg, 8'h01);
        bus_write(12'h400, 8'hF1);             // pin 0 turns output on capture edge
        chk("R10 capture used old dir", pad_out, 8'h0E);
        bus_read(12'h3FC, v); chk("R10 data after dir collide", v, 8'h06);
        chk("R8 no pulse on output pin", in_chg, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_dir();
        t_masked_write();
        t_masked_read();
        t_input();
        t_unmapped();
        t_collide();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule